// File: doc/BRIEF.md
# Double-Buffered DAC Host Interface

This block sits between a parallel processor bus and a 16-bit digital-to-analog converter. It holds two registers. The staging register is written from a 16-bit data bus and can be read back onto that bus. The converter register drives the DAC code. Four active-low strobes control it:
- a select that enables bus access;
- a read/write-not line that gives the direction of a bus access and also picks the clear code;
- a load strobe that copies the staging register into the converter register;
- a clear strobe that forces the converter register to one of two fixed codes.

Every control strobe passes through a multi-flop synchroniser before it acts, and the data bus is delayed by the same number of stages. The path from a strobe edge to the converter code therefore has a fixed latency. Several copies of the block that share one load strobe update their converter codes on the same clock edge.

On each leading edge of the load strobe the block also drives a hold pulse of fixed length. The pulse freezes the analog track-and-hold stage while the converter changes code. If the load strobe stays asserted, the converter register follows the staging register continuously and no hold pulse is produced. Because the bus is split into an input, an output and an output enable, the pad ring can build the tri-state driver.

Top module: `dacbus_if`

## Requirements
- R1: After reset the staging register and the converter code are both 0x0000, `bus_oe` is 0, `bus_out` is 0 and `hold_n` is 1.
- R2: While `sel_n` is high, `bus_oe` stays 0 and `bus_out` stays 0. Bus activity with `rd_wr_n` low does not change the staging register.
- R3: With `sel_n` low and `rd_wr_n` low, the word on `bus_in` is stored in the staging register.
- R4: With `sel_n` low and `rd_wr_n` high, `bus_oe` is 1 and `bus_out` carries the staging register. A read does not alter the staging register.
- R5: With `load_n` low and `clr_n` high, the converter code takes the staging register value. This happens whatever the state of `sel_n`.
- R6: With `clr_n` low and `rd_wr_n` low, the converter code becomes 0x0000 and stays there after `clr_n` is released.
- R7: With `clr_n` low and `rd_wr_n` high, the converter code becomes the mid-scale code. In that code only the most significant bit is set (0x8000 for 16 bits).
- R8: When `clr_n` and `load_n` are both low, the clear code wins over the staging register.
- R9: A falling edge on `load_n` drives `hold_n` low for exactly HOLD_CYC clock cycles. `hold_n` falls on the same edge on which the converter code changes.
- R10: A new falling edge on `load_n` during a hold restarts the count. `hold_n` then stays low without a gap until HOLD_CYC cycles after the new edge.
- R11: While `load_n` stays low, later writes reach the converter code with no further hold pulse. A `load_n` held low from reset never produces a hold pulse.
- R12: The converter code changes on the (SYNC_STAGES+1)-th rising clock edge after `load_n` falls, so interfaces sharing one strobe update together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select for bus access |
| rd_wr_n | input | 1 | High reads the staging register, low writes it; also selects the clear code |
| load_n | input | 1 | Active-low transfer strobe into the converter register |
| clr_n | input | 1 | Active-low clear of the converter register |
| bus_in | input | DATA_W | Write data from the bus |
| bus_out | output | DATA_W | Readback data, zero when not driving |
| bus_oe | output | 1 | Output enable for the bus pad drivers |
| dac_code | output | DATA_W | Code applied to the converter |
| hold_n | output | 1 | Active-low hold for the output track-and-hold |

## Verification
Some rules are checked by the assertions on every cycle:
- a write updates the staging register;
- the staging register does not change outside a write or during a read;
- each clear code, and its priority over load, lands one cycle after the synchronised strobe;
- a transfer copies the staging register;
- the hold counter counts down by one each cycle;
- a hold can start only on a load edge.

Other behaviour appears only across a sequence of bus cycles, so only the bench scenarios can show it:
- the exact hold length, and how it stretches on a retrigger;
- the fixed latency from strobe to code;
- readback through the bus;
- the absence of a pulse while the load strobe is held low.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;

   // Synchronised control bundle, all fields active-high
   typedef struct packed {
      logic cs;    // bus access selected
      logic rd;    // read direction / mid-scale clear choice
      logic ld;    // transfer requested
      logic clr;   // clear requested
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   // Reset image of the synchroniser: load counts as already asserted so a
   // strobe tied active from power-up never looks like a fresh edge.
   localparam ctrl_t CTRL_RST = '{cs: 1'b0, rd: 1'b0, ld: 1'b1, clr: 1'b0};

endpackage

// File: rtl/dacbus_sync.sv
module dacbus_sync #(
   parameter int               W       = 4,
   parameter int               STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dacbus_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= RST_VAL;
         end else if (s == 0) begin
            stage_q[s] <= d;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dacbus_latches.sv
module dacbus_latches
   import dacbus_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_t             ctl,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] stage_q,
   output logic [DATA_W-1:0] conv_q
);

   localparam logic [DATA_W-1:0] CODE_ZERO = '0;
   localparam logic [DATA_W-1:0] CODE_MID  = {1'b1, {(DATA_W-1){1'b0}}};

   logic wr_en;
   assign wr_en = ctl.cs & ~ctl.rd;

   // Staging register, written from the bus
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= CODE_ZERO;
      end else if (wr_en) begin
         stage_q <= wdata;
      end
   end

   // Converter register: clear outranks transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q <= CODE_ZERO;
      end else if (ctl.clr) begin
         conv_q <= ctl.rd ? CODE_MID : CODE_ZERO;
      end else if (ctl.ld) begin
         conv_q <= stage_q;
      end
   end

   AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.cs && !ctl.rd) |=> stage_q == $past(wdata)); // R3
   AST_STAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl.cs && !ctl.rd) |=> $stable(stage_q)); // R2
   AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.cs && ctl.rd) |=> $stable(stage_q)); // R4
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.clr && !ctl.rd) |=> conv_q == CODE_ZERO); // R6
   AST_CLEAR_MID: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.clr && ctl.rd) |=> conv_q == CODE_MID); // R7
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.clr && ctl.ld && stage_q != CODE_MID && stage_q != CODE_ZERO)
      |=> conv_q != $past(stage_q)); // R8
   AST_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.ld && !ctl.clr) |=> conv_q == $past(stage_q)); // R5

endmodule

// File: rtl/dacbus_hold.sv
module dacbus_hold #(
   parameter int HOLD_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_act,
   output logic hold_n
);

   if (HOLD_CYC < 0) begin : g_bad_hold
      $error("dacbus_hold: HOLD_CYC must not be negative");
   end

   if (HOLD_CYC == 0) begin : g_no_deglitch
      logic unused_ld;
      assign unused_ld = ld_act ^ clk ^ rst_n;
      assign hold_n    = 1'b1;
   end else begin : g_deglitch
      localparam int CNT_W = $clog2(HOLD_CYC + 1);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC);

      logic [CNT_W-1:0] cnt_q;
      logic             ld_prev_q;
      logic             ld_edge;

      assign ld_edge = ld_act & ~ld_prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q     <= '0;
            ld_prev_q <= 1'b1;
         end else begin
            ld_prev_q <= ld_act;
            if (ld_edge) begin
               cnt_q <= CNT_LOAD;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end

      assign hold_n = (cnt_q == '0);

      AST_HOLD_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
         ld_edge |=> !hold_n); // R9
      AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q != '0 && !ld_edge) |=> cnt_q == $past(cnt_q) - 1'b1); // R9
      AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
         ld_edge |=> cnt_q == CNT_LOAD); // R10
      AST_NO_SPURIOUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (hold_n && !ld_edge) |=> hold_n); // R11
   end

endmodule

// File: rtl/dacbus_if.sv
module dacbus_if
   import dacbus_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYC    = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              rd_wr_n,
   input  logic              load_n,
   input  logic              clr_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic [DATA_W-1:0] dac_code,
   output logic              hold_n
);

   if (DATA_W < 2) begin : g_bad_width
      $error("dacbus_if: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dacbus_if: SYNC_STAGES must be at least 2");
   end

   ctrl_t             ctl_raw;
   ctrl_t             ctl_s;
   logic [CTRL_W-1:0] ctl_s_vec;
   logic [DATA_W-1:0] data_s;
   logic [DATA_W-1:0] stage_q;
   logic [DATA_W-1:0] conv_q;

   always_comb begin
      ctl_raw.cs  = ~sel_n;
      ctl_raw.rd  = rd_wr_n;
      ctl_raw.ld  = ~load_n;
      ctl_raw.clr = ~clr_n;
   end

   dacbus_sync #(
      .W       (CTRL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTRL_RST)
   ) i_ctl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s_vec)
   );

   assign ctl_s = ctrl_t'(ctl_s_vec);

   // Data is delayed by the same depth so it lines up with the write strobe
   dacbus_sync #(
      .W       (DATA_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) i_data_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_in),
      .q     (data_s)
   );

   dacbus_latches #(
      .DATA_W (DATA_W)
   ) i_latches (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl_s),
      .wdata   (data_s),
      .stage_q (stage_q),
      .conv_q  (conv_q)
   );

   dacbus_hold #(
      .HOLD_CYC (HOLD_CYC)
   ) i_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_act (ctl_s.ld),
      .hold_n (hold_n)
   );

   assign bus_oe   = ctl_s.cs & ctl_s.rd;
   assign bus_out  = bus_oe ? stage_q : '0;
   assign dac_code = conv_q;

   AST_READBACK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> bus_out == stage_q); // R4
   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_s.cs |-> (!bus_oe && bus_out == '0)); // R2

endmodule

// File: tb/test_dacbus_if.sv
module test_dacbus_if;

   localparam int DW   = 16;
   localparam int SYNC = 2;
   localparam int HOLD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_n = 1'b1;
   logic          rd_wr_n = 1'b0;
   logic          load_n = 1'b1;
   logic          clr_n = 1'b1;
   logic [DW-1:0] bus_in = '0;
   logic [DW-1:0] bus_out;
   logic          bus_oe;
   logic [DW-1:0] dac_code;
   logic          hold_n;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   dacbus_if #(.DATA_W(DW), .SYNC_STAGES(SYNC), .HOLD_CYC(HOLD)) i_dacbus_if (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr_n(rd_wr_n),
      .load_n(load_n), .clr_n(clr_n), .bus_in(bus_in), .bus_out(bus_out),
      .bus_oe(bus_oe), .dac_code(dac_code), .hold_n(hold_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [DW-1:0] v);
      sel_n = 1'b0; rd_wr_n = 1'b0; bus_in = v;
      idle(4);
      sel_n = 1'b1;
      idle(4);
   endtask

   task automatic bus_read_check(input string tag, input logic [DW-1:0] exp);
      sel_n = 1'b0; rd_wr_n = 1'b1;
      idle(4);
      chk({tag, " oe"}, 32'(bus_oe), 32'd1);
      chk({tag, " data"}, 32'(bus_out), 32'(exp));
      sel_n = 1'b1; rd_wr_n = 1'b0;
      idle(4);
   endtask

   task automatic load_pulse();
      load_n = 1'b0;
      idle(4);
      load_n = 1'b1;
      idle(HOLD + 4);
   endtask

   task automatic t_reset();
      chk("R1 dac", 32'(dac_code), 32'h0);
      chk("R1 oe", 32'(bus_oe), 32'd0);
      chk("R1 out", 32'(bus_out), 32'h0);
      chk("R1 hold", 32'(hold_n), 32'd1);
      bus_read_check("R1 stage", 16'h0000);
   endtask

   task automatic t_write_read();
      bus_write(16'hA5C3);
      bus_read_check("R3 write", 16'hA5C3);
      bus_read_check("R4 reread", 16'hA5C3);
      bus_write(16'h0F0F);
      bus_read_check("R3 second", 16'h0F0F);
   endtask

   task automatic t_cs_idle();
      bus_in = 16'hDEAD; rd_wr_n = 1'b0; sel_n = 1'b1;
      idle(5);
      chk("R2 oe", 32'(bus_oe), 32'd0);
      chk("R2 out", 32'(bus_out), 32'h0);
      rd_wr_n = 1'b1;
      idle(5);
      chk("R2 oe rd", 32'(bus_oe), 32'd0);
      rd_wr_n = 1'b0;
      bus_read_check("R2 ignored", 16'h0F0F);
   endtask

   task automatic t_transfer_latency();
      int lowcnt;
      bus_write(16'h1357);
      sel_n = 1'b0; rd_wr_n = 1'b1;
      load_n = 1'b0;
      for (int k = 1; k <= SYNC; k++) begin
         @(negedge clk);
         chk("R12 before", 32'(dac_code), 32'h0);
      end
      @(negedge clk);
      chk("R12 edge", 32'(dac_code), 32'h1357);
      chk("R5 cs ignored", 32'(dac_code), 32'h1357);
      lowcnt = 0;
      while (hold_n == 1'b0 && lowcnt < 100) begin
         lowcnt++;
         @(negedge clk);
      end
      chk("R9 length", 32'(lowcnt), 32'(HOLD));
      load_n = 1'b1; sel_n = 1'b1; rd_wr_n = 1'b0;
      idle(4);
   endtask

   task automatic t_retrigger();
      int lowcnt;
      logic gap;
      gap = 1'b0;
      load_n = 1'b0;
      idle(SYNC + 1);
      chk("R9 start", 32'(hold_n), 32'd0);
      idle(2);
      load_n = 1'b1;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         if (hold_n) gap = 1'b1;
      end
      load_n = 1'b0;
      for (int k = 0; k < SYNC + 1; k++) begin
         @(negedge clk);
         if (hold_n) gap = 1'b1;
      end
      chk("R10 no gap", 32'(gap), 32'd0);
      lowcnt = 0;
      while (hold_n == 1'b0 && lowcnt < 100) begin
         lowcnt++;
         @(negedge clk);
      end
      chk("R10 restarted length", 32'(lowcnt), 32'(HOLD));
      load_n = 1'b1;
      idle(4);
   endtask

   task automatic t_clear_zero();
      rd_wr_n = 1'b0; clr_n = 1'b0;
      idle(4);
      chk("R6 zero", 32'(dac_code), 32'h0);
      clr_n = 1'b1;
      idle(4);
      chk("R6 kept", 32'(dac_code), 32'h0);
   endtask

   task automatic t_clear_mid();
      load_pulse();
      chk("R5 reload", 32'(dac_code), 32'h1357);
      rd_wr_n = 1'b1; clr_n = 1'b0;
      idle(4);
      chk("R7 mid", 32'(dac_code), 32'h8000);
      clr_n = 1'b1; rd_wr_n = 1'b0;
      idle(4);
   endtask

   task automatic t_clear_priority();
      bus_write(16'h1234);
      rd_wr_n = 1'b0; clr_n = 1'b0; load_n = 1'b0;
      idle(5);
      chk("R8 clear wins", 32'(dac_code), 32'h0);
      clr_n = 1'b1;
      idle(4);
      chk("R8 load after clear", 32'(dac_code), 32'h1234);
      load_n = 1'b1;
      idle(HOLD + 4);
   endtask

   task automatic t_load_tied();
      int lowcnt;
      load_n = 1'b0;
      idle(HOLD + 6);
      lowcnt = 0;
      sel_n = 1'b0; rd_wr_n = 1'b0; bus_in = 16'hBEEF;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (!hold_n) lowcnt++;
      end
      sel_n = 1'b1;
      for (int k = 0; k < 3 * HOLD; k++) begin
         @(negedge clk);
         if (!hold_n) lowcnt++;
      end
      chk("R11 follows", 32'(dac_code), 32'hBEEF);
      chk("R11 no pulse", 32'(lowcnt), 32'd0);
      load_n = 1'b1;
      idle(HOLD + 4);
   endtask

   task automatic t_tied_from_reset();
      int lowcnt;
      rst_n = 1'b0; load_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      lowcnt = 0;
      for (int k = 0; k < 3 * HOLD; k++) begin
         @(negedge clk);
         if (!hold_n) lowcnt++;
      end
      chk("R11 reset tied", 32'(lowcnt), 32'd0);
      load_n = 1'b1;
      idle(4);
   endtask

   initial begin
      #(8 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(4);
      t_reset();
      t_write_read();
      t_cs_idle();
      t_transfer_latency();
      t_retrigger();
      t_clear_zero();
      t_clear_mid();
      t_clear_priority();
      t_load_tied();
      t_tied_from_reset();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule